// File: doc/BRIEF.md
# Lockstep Execute Compare with Branch-Style Replay

This block watches two in-order pipelines that run the same program in lockstep. In every cycle it compares what the two lanes hold in their execute stage: the valid bit, the program counter and the computed result. When the lanes agree, it grants a commit to the instruction that is leaving execute. When they disagree, it treats the next older instruction as if that instruction were a mispredicted branch. It flushes every stage younger than that instruction and steers fetch back to the address of the faulty instruction, so that instruction runs again from the fetch stage. No checkpoint is stored. The state that instructions older than the faulty one have already committed is the state the replay continues from.

The block also merges the pipelines' own branch-mispredict reports into the same flush and redirect path, and settles the priority by age. A saturating counter records how many replays have been triggered. All outputs are registered. The pipeline applies them in the cycle after the compare, so a flush mask names the stage positions the instructions occupy in that later cycle. The instruction that was compared has by then moved one stage on (stage index EX_IDX+1).

Top module: `lockstep_rollback`

## Requirements
- R1: While reset is high, and in every cycle after reset in which no instruction or branch event has been presented, flush_mask, redirect_valid, redirect_pc, commit_en, err_flag and recover_count are all zero.
- R2: When both lanes are valid with equal PCs and equal results, and there is no branch event, the next cycle shows commit_en=1, err_flag=0, redirect_valid=0 and flush_mask=0, and recover_count is unchanged.
- R3: When both lanes are valid and their PCs or their results differ, the next cycle shows err_flag=1, commit_en=0, redirect_valid=1, redirect_pc equal to lane A's execute PC, and flush_mask with bits 0 to EX_IDX+1 set (5'b01111 with the default parameters). recover_count increases by one.
- R4: When exactly one lane is valid, the case is handled as an error exactly as in R3, but redirect_pc is the PC of the lane that is valid.
- R5: When both lanes are invalid, nothing happens, whatever their PCs and results hold: the next cycle shows no commit, no flush, no redirect and no error, and the count is unchanged.
- R6: recover_count increases by exactly one for each replay and holds at 2^CNT_W-1 once it has reached that value (255 by default).
- R7: A mispredict reported for an instruction older than execute (br_from_ex=0) beats a compare error in the same cycle. The next cycle shows redirect_pc=br_target, flush_mask bits 0 to EX_IDX+1 set, commit_en=0 and err_flag=0, and recover_count is unchanged.
- R8: A mispredict reported for the execute instruction itself (br_from_ex=1) on matching lanes gives, in the next cycle, redirect_pc=br_target, flush_mask bits 0 to EX_IDX set (5'b00111), commit_en=1 and err_flag=0. If that instruction also mismatches, the error wins and the outcome is that of R3.
- R9: In a cycle in which flush_mask is nonzero, the execute inputs and branch inputs are ignored. The following cycle shows no flush, no redirect, no commit and no error, and the count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid_a | input | 1 | Lane A execute stage holds an instruction |
| ex_pc_a | input | PC_W | Lane A execute-stage PC |
| ex_res_a | input | RES_W | Lane A execute result |
| ex_valid_b | input | 1 | Lane B execute stage holds an instruction |
| ex_pc_b | input | PC_W | Lane B execute-stage PC |
| ex_res_b | input | RES_W | Lane B execute result |
| br_mispred | input | 1 | Pipeline reports a branch mispredict this cycle |
| br_from_ex | input | 1 | 1: mispredicting branch is the execute instruction; 0: it is older |
| br_target | input | PC_W | Correct target of the mispredicted branch |
| flush_mask | output | NSTAGES | One bit per stage position (bit 0 = fetch) to discard |
| redirect_valid | output | 1 | Fetch must restart at redirect_pc |
| redirect_pc | output | PC_W | Restart address |
| commit_en | output | 1 | Instruction that left execute may update architectural state in both lanes |
| err_flag | output | 1 | A lockstep replay was triggered |
| recover_count | output | CNT_W | Saturating number of replays |

## Verification
On every cycle, the assertions check the following relations. A replay never comes with a commit, and it always raises a redirect with a deep flush. The flush mask is nonzero exactly when a redirect is present, and it is a contiguous run starting at fetch. A redirect is never followed by a second one, and the counter only steps by one or holds at its ceiling. Only the directed scenarios can show the values themselves: which PC is chosen in each case, which mask depth goes with which branch age, the priority between an error and a branch in the same cycle, that bubbles and inputs during a flush are ignored, and that the count really stops at 255.

// File: rtl/lsr_pkg.sv
`timescale 1ns/1ps
package lsr_pkg;

  typedef enum logic [1:0] {
    ACT_IDLE,
    ACT_COMMIT,
    ACT_REPLAY,
    ACT_BRANCH
  } lsr_act_e;

  function automatic logic [31:0] low_ones(input int unsigned n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/lsr_compare.sv
`timescale 1ns/1ps
module lsr_compare #(
  parameter int PC_W  = 32,
  parameter int RES_W = 32
) (
  input  logic             va,
  input  logic [PC_W-1:0]  pca,
  input  logic [RES_W-1:0] ra,
  input  logic             vb,
  input  logic [PC_W-1:0]  pcb,
  input  logic [RES_W-1:0] rb,
  output logic             mismatch,
  output logic             agree,
  output logic [PC_W-1:0]  fault_pc
);

  logic both_on;
  logic split;
  logic differ;

  always_comb begin
    both_on  = va & vb;
    split    = va ^ vb;
    differ   = (pca != pcb) | (ra != rb);
    mismatch = split | (both_on & differ);
    agree    = both_on & ~differ;
    fault_pc = va ? pca : pcb;
  end

endmodule

// File: rtl/lsr_arbiter.sv
`timescale 1ns/1ps
module lsr_arbiter
  import lsr_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int NSTAGES = 5,
  parameter int EX_IDX  = 2
) (
  input  logic               hold_off,
  input  logic               mismatch,
  input  logic               agree,
  input  logic [PC_W-1:0]    fault_pc,
  input  logic               br_mispred,
  input  logic               br_from_ex,
  input  logic [PC_W-1:0]    br_target,
  output lsr_act_e           act,
  output logic [NSTAGES-1:0] nxt_mask,
  output logic               nxt_redirect,
  output logic [PC_W-1:0]    nxt_pc,
  output logic               nxt_commit,
  output logic               nxt_replay
);

  localparam int DEEP_N    = EX_IDX + 2;
  localparam int SHALLOW_N = EX_IDX + 1;

  logic [NSTAGES-1:0] mask_deep;
  logic [NSTAGES-1:0] mask_shallow;

  for (genvar g = 0; g < NSTAGES; g++) begin : g_mask
    assign mask_deep[g]    = (g < DEEP_N);
    assign mask_shallow[g] = (g < SHALLOW_N);
  end

  always_comb begin
    act = ACT_IDLE;
    if (hold_off)                      act = ACT_IDLE;
    else if (br_mispred && !br_from_ex) act = ACT_BRANCH;
    else if (mismatch)                 act = ACT_REPLAY;
    else if (br_mispred)               act = ACT_BRANCH;
    else if (agree)                    act = ACT_COMMIT;
  end

  always_comb begin
    nxt_mask     = '0;
    nxt_redirect = 1'b0;
    nxt_pc       = '0;
    nxt_commit   = 1'b0;
    nxt_replay   = 1'b0;
    unique case (act)
      ACT_REPLAY: begin
        nxt_mask     = mask_deep;
        nxt_redirect = 1'b1;
        nxt_pc       = fault_pc;
        nxt_replay   = 1'b1;
      end
      ACT_BRANCH: begin
        nxt_mask     = br_from_ex ? mask_shallow : mask_deep;
        nxt_redirect = 1'b1;
        nxt_pc       = br_target;
        nxt_commit   = br_from_ex & agree;
      end
      ACT_COMMIT: nxt_commit = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/lsr_counter.sv
`timescale 1ns/1ps
module lsr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                        cnt <= '0;
    else if (bump && cnt != CNT_TOP) cnt <= cnt + 1'b1;
  end

  assert_cnt_step_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_cnt_hold_top_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt) == CNT_TOP) |-> (cnt == CNT_TOP));

endmodule

// File: rtl/lockstep_rollback.sv
`timescale 1ns/1ps
module lockstep_rollback
  import lsr_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int RES_W   = 32,
  parameter int NSTAGES = 5,
  parameter int EX_IDX  = 2,
  parameter int CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ex_valid_a,
  input  logic [PC_W-1:0]    ex_pc_a,
  input  logic [RES_W-1:0]   ex_res_a,
  input  logic               ex_valid_b,
  input  logic [PC_W-1:0]    ex_pc_b,
  input  logic [RES_W-1:0]   ex_res_b,
  input  logic               br_mispred,
  input  logic               br_from_ex,
  input  logic [PC_W-1:0]    br_target,
  output logic [NSTAGES-1:0] flush_mask,
  output logic               redirect_valid,
  output logic [PC_W-1:0]    redirect_pc,
  output logic               commit_en,
  output logic               err_flag,
  output logic [CNT_W-1:0]   recover_count
);

  logic               mismatch;
  logic               agree;
  logic [PC_W-1:0]    fault_pc;
  logic               hold_off;
  lsr_act_e           act;
  logic [NSTAGES-1:0] nxt_mask;
  logic               nxt_redirect;
  logic [PC_W-1:0]    nxt_pc;
  logic               nxt_commit;
  logic               nxt_replay;

  assign hold_off = |flush_mask;

  lsr_compare #(.PC_W(PC_W), .RES_W(RES_W)) u_cmp (
    .va(ex_valid_a), .pca(ex_pc_a), .ra(ex_res_a),
    .vb(ex_valid_b), .pcb(ex_pc_b), .rb(ex_res_b),
    .mismatch(mismatch), .agree(agree), .fault_pc(fault_pc)
  );

  lsr_arbiter #(.PC_W(PC_W), .NSTAGES(NSTAGES), .EX_IDX(EX_IDX)) u_arb (
    .hold_off(hold_off), .mismatch(mismatch), .agree(agree),
    .fault_pc(fault_pc), .br_mispred(br_mispred), .br_from_ex(br_from_ex),
    .br_target(br_target), .act(act), .nxt_mask(nxt_mask),
    .nxt_redirect(nxt_redirect), .nxt_pc(nxt_pc),
    .nxt_commit(nxt_commit), .nxt_replay(nxt_replay)
  );

  lsr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .bump(nxt_replay), .cnt(recover_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_mask     <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      commit_en      <= 1'b0;
      err_flag       <= 1'b0;
    end else begin
      flush_mask     <= nxt_mask;
      redirect_valid <= nxt_redirect;
      redirect_pc    <= nxt_pc;
      commit_en      <= nxt_commit;
      err_flag       <= nxt_replay;
    end
  end

  assert_replay_no_commit_R3: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> !commit_en);

  assert_replay_deep_flush_R3: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> (redirect_valid && flush_mask[EX_IDX+1]));

  assert_mask_pairs_redirect_R7: assert property (@(posedge clk) disable iff (rst)
    (flush_mask != '0) == redirect_valid);

  assert_mask_contiguous_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flush_mask + 1'b1));

  assert_no_back_to_back_R9: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |=> !redirect_valid);

  assert_act_known_R2: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_COMMIT) |-> !mismatch);

endmodule

// File: tb/test_lockstep_rollback.sv
`timescale 1ns/1ps
module test_lockstep_rollback;

  localparam int PC_W = 32, RES_W = 32, NSTAGES = 5, EX_IDX = 2, CNT_W = 8;
  localparam logic [NSTAGES-1:0] DEEP    = 5'b01111;
  localparam logic [NSTAGES-1:0] SHALLOW = 5'b00111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic va, vb, brm, brx;
  logic [PC_W-1:0] pca, pcb, brt;
  logic [RES_W-1:0] ra, rb;
  logic [NSTAGES-1:0] flush_mask;
  logic redirect_valid, commit_en, err_flag;
  logic [PC_W-1:0] redirect_pc;
  logic [CNT_W-1:0] recover_count;

  int n_run = 0;
  int n_fail = 0;
  int exp_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lockstep_rollback #(.PC_W(PC_W), .RES_W(RES_W), .NSTAGES(NSTAGES),
                      .EX_IDX(EX_IDX), .CNT_W(CNT_W)) i_lockstep_rollback (
    .clk(clk), .rst(rst),
    .ex_valid_a(va), .ex_pc_a(pca), .ex_res_a(ra),
    .ex_valid_b(vb), .ex_pc_b(pcb), .ex_res_b(rb),
    .br_mispred(brm), .br_from_ex(brx), .br_target(brt),
    .flush_mask(flush_mask), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc), .commit_en(commit_en),
    .err_flag(err_flag), .recover_count(recover_count)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic outs(input string req, input logic [NSTAGES-1:0] m,
                      input logic rv, input logic [PC_W-1:0] pc,
                      input logic ce, input logic ef);
    chk(req, "flush_mask", 64'(flush_mask), 64'(m));
    chk(req, "redirect_valid", 64'(redirect_valid), 64'(rv));
    if (rv) chk(req, "redirect_pc", 64'(redirect_pc), 64'(pc));
    chk(req, "commit_en", 64'(commit_en), 64'(ce));
    chk(req, "err_flag", 64'(err_flag), 64'(ef));
    chk(req, "recover_count", 64'(recover_count), 64'(exp_cnt));
  endtask

  task automatic drive(input logic a_v, input logic [PC_W-1:0] a_pc, input logic [RES_W-1:0] a_r,
                       input logic b_v, input logic [PC_W-1:0] b_pc, input logic [RES_W-1:0] b_r,
                       input logic bm, input logic bx, input logic [PC_W-1:0] bt);
    va = a_v; pca = a_pc; ra = a_r;
    vb = b_v; pcb = b_pc; rb = b_r;
    brm = bm; brx = bx; brt = bt;
  endtask

  task automatic idle();
    drive(0, '0, '0, 0, '0, '0, 0, 0, '0);
  endtask

  // one compare cycle, then one idle cycle so any flush clears
  task automatic step_and_settle();
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    outs("R1", '0, 0, '0, 0, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    outs("R1", '0, 0, '0, 0, 0);
  endtask

  task automatic t_match();
    drive(1, 32'h100, 32'hdead_beef, 1, 32'h100, 32'hdead_beef, 0, 0, '0);
    @(negedge clk);
    drive(1, 32'h104, 32'h0, 1, 32'h104, 32'h0, 0, 0, '0);
    outs("R2", '0, 0, '0, 1, 0);
    @(negedge clk);
    idle();
    outs("R2", '0, 0, '0, 1, 0);
    @(negedge clk);
  endtask

  task automatic t_mismatch();
    drive(1, 32'h200, 32'h1, 1, 32'h200, 32'h3, 0, 0, '0);
    step_and_settle();
    exp_cnt++;
    outs("R3", DEEP, 1, 32'h200, 0, 1);
    @(negedge clk);
    outs("R3", '0, 0, '0, 0, 0);
    drive(1, 32'h300, 32'h7, 1, 32'h304, 32'h7, 0, 0, '0);
    step_and_settle();
    exp_cnt++;
    outs("R3", DEEP, 1, 32'h300, 0, 1);
    @(negedge clk);
  endtask

  task automatic t_split();
    drive(1, 32'h400, 32'h5, 0, 32'h999, 32'h5, 0, 0, '0);
    step_and_settle();
    exp_cnt++;
    outs("R4", DEEP, 1, 32'h400, 0, 1);
    @(negedge clk);
    drive(0, 32'h888, 32'h5, 1, 32'h410, 32'h5, 0, 0, '0);
    step_and_settle();
    exp_cnt++;
    outs("R4", DEEP, 1, 32'h410, 0, 1);
    @(negedge clk);
  endtask

  task automatic t_bubble();
    drive(0, 32'h500, 32'h1, 0, 32'h600, 32'h2, 0, 0, '0);
    step_and_settle();
    outs("R5", '0, 0, '0, 0, 0);
    @(negedge clk);
  endtask

  task automatic t_branch_older();
    drive(1, 32'h700, 32'h1, 1, 32'h700, 32'h2, 1, 0, 32'h1234);
    step_and_settle();
    outs("R7", DEEP, 1, 32'h1234, 0, 0);
    @(negedge clk);
    drive(1, 32'h704, 32'h1, 1, 32'h704, 32'h1, 1, 0, 32'h2000);
    step_and_settle();
    outs("R7", DEEP, 1, 32'h2000, 0, 0);
    @(negedge clk);
  endtask

  task automatic t_branch_ex();
    drive(1, 32'h800, 32'h9, 1, 32'h800, 32'h9, 1, 1, 32'h3000);
    step_and_settle();
    outs("R8", SHALLOW, 1, 32'h3000, 1, 0);
    @(negedge clk);
    drive(1, 32'h804, 32'h9, 1, 32'h804, 32'h8, 1, 1, 32'h3000);
    step_and_settle();
    exp_cnt++;
    outs("R8", DEEP, 1, 32'h804, 0, 1);
    @(negedge clk);
  endtask

  task automatic t_holdoff();
    drive(1, 32'h900, 32'h1, 1, 32'h900, 32'h2, 0, 0, '0);
    @(negedge clk);
    exp_cnt++;
    outs("R9", DEEP, 1, 32'h900, 0, 1);
    drive(1, 32'h904, 32'h1, 0, 32'h904, 32'h2, 1, 0, 32'h4444);
    @(negedge clk);
    idle();
    outs("R9", '0, 0, '0, 0, 0);
    @(negedge clk);
    outs("R9", '0, 0, '0, 0, 0);
  endtask

  task automatic t_saturate();
    while (exp_cnt < 255) begin
      drive(1, 32'ha00, 32'h1, 1, 32'ha00, 32'h0, 0, 0, '0);
      step_and_settle();
      exp_cnt++;
      @(negedge clk);
    end
    chk("R6", "count at top", 64'(recover_count), 64'd255);
    drive(1, 32'ha04, 32'h1, 1, 32'ha04, 32'h0, 0, 0, '0);
    step_and_settle();
    outs("R6", DEEP, 1, 32'ha04, 0, 1);
    @(negedge clk);
    chk("R6", "count held", 64'(recover_count), 64'd255);
  endtask

  initial begin
    idle();
    t_reset();
    t_match();
    t_mismatch();
    t_split();
    t_bubble();
    t_branch_older();
    t_branch_ex();
    t_holdoff();
    t_saturate();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule